// File: doc/BRIEF.md
# Instruction Scheduling State Machine

This block is the per-instruction scheduler that sits beside the instruction decoder of a small 8-bit core. Each cycle the decoder presents a handful of flags describing the instruction in the instruction register. The scheduler uses them to decide whether that instruction finishes in one cycle, needs an extra cycle, or halts the core. It drives the fetch-stall, writeback-enable and PC-increment strobes.

Single-cycle instructions run back to back. A prefix moves the machine into a dedicated prefix state. That state acts like the normal execute state, except that a stop of free-running mode cannot send it to idle, so the prefixed instruction always executes. Constant loads and PC writes that go through the slow half of the datapath each get exactly one extra stall cycle.

The scheduler stops, and reports a 2-bit cause to the system sequencer, in four cases:
- an invalid opcode;
- a second prefix in a row;
- an overlay-switch request (a CALL whose destination is the PC);
- an overlay request for the reserved number 255, which means halt.

The stop state holds until the system sequencer clears it. The decoding itself and the datapath are outside this block.

Top module: `insn_sched`

## Requirements
- R1: While `rstN` is low and just after it is released, `stateOut` is 0 (idle), `stopped` is 0, `fetchStall` is 1, and `wbEn` and `pcIncEn` are 0.
- R2: From idle (code 0), a high `runMode` or `stepReq` moves the machine to execute (code 1). In execute, an instruction with no flag set gives `wbEn`=1, `pcIncEn`=1 and `fetchStall`=0. The next state is execute when `runMode` is high and idle otherwise.
- R3: In execute, `isPrefix` moves the machine to the prefix state (code 2), with `wbEn`=0 and `pcIncEn`=1. In the prefix state, an instruction with no flag set returns to execute whatever `runMode` is, and never goes to idle.
- R4: In execute or prefix, `isLdc` moves the machine to the constant-load state (code 3) for exactly one cycle. In that cycle `fetchStall`=1 and `wbEn`=`pcIncEn`=0. The state after it is execute if `runMode` is high, else idle.
- R5: In execute or prefix, `writesPc` moves the machine to the PC-stall state (code 4) for exactly one cycle. The strobes and the following state are the same as in R4.
- R6: In execute or prefix, `invalid` moves the machine to stop (code 5) with `stopReason` 0.
- R7: `isPrefix` while in the prefix state moves the machine to stop with `stopReason` 1.
- R8: `isOvl` with `ovlNum` other than 255 moves the machine to stop with `stopReason` 2, and `ovlOut` takes `ovlNum`.
- R9: `isOvl` with `ovlNum` equal to 255 moves the machine to stop with `stopReason` 3, and `ovlOut` takes 255.
- R10: In stop, `stopped`=1, `fetchStall`=1 and `wbEn`=`pcIncEn`=0. All decode flags, `runMode` and `stepReq` are ignored. The only exit is `stopClr`, which leads to idle.
- R11: When several flags are set together, the order of precedence is invalid, then double prefix, then overlay, then prefix, then constant load, then PC write. In any cycle that moves to stop, `wbEn`=0 and `pcIncEn`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| runMode | input | 1 | Free-running execution requested |
| stepReq | input | 1 | Execute one instruction from idle |
| stopClr | input | 1 | Sequencer clears the stop state |
| isPrefix | input | 1 | Current instruction is a prefix |
| isLdc | input | 1 | Current instruction is a constant load |
| writesPc | input | 1 | Current instruction writes the PC through the slow path |
| isOvl | input | 1 | Current instruction is a CALL to PC (overlay switch) |
| invalid | input | 1 | Current opcode is undefined |
| ovlNum | input | 8 | Overlay number carried by the overlay request |
| fetchStall | output | 1 | Hold instruction fetch this cycle |
| wbEn | output | 1 | Allow register writeback this cycle |
| pcIncEn | output | 1 | Allow the PC to advance this cycle |
| stopped | output | 1 | Scheduler sits in the stop state |
| stopReason | output | 2 | Cause of the last stop: 0 invalid, 1 double prefix, 2 overlay, 3 halt |
| ovlOut | output | 8 | Overlay number of the last overlay request |
| stateOut | output | 3 | Current state code |

## Verification
The bench goes after chained multi-cycle cases: a prefix followed by a constant load or a PC write. A design that got this wrong would fall into an unlisted state or skip the stall cycle. It drops `runMode` while a prefix is pending. A design that let the idle exit through there would lose the prefixed instruction and end in idle. It also sends flag combinations that test precedence (invalid together with overlay, prefix-prefix together with a load) and overlay numbers 254 and 255. A wrong order or a wrong halt compare would report the wrong cause or go on executing. Finally, it holds random flags while the machine is stopped, which would move a stop state that does not fully ignore them.

// File: rtl/insn_sched_pkg.sv
package insn_sched_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_INST    = 3'd1,
    S_PRFX    = 3'd2,
    S_LDC     = 3'd3,
    S_PCSTALL = 3'd4,
    S_STOP    = 3'd5
  } schedState_t;

  typedef enum logic [1:0] {
    R_INVALID = 2'd0,
    R_DBLPFX  = 2'd1,
    R_OVL     = 2'd2,
    R_HALT    = 2'd3
  } stopReason_t;

  // Strobes from control into the cause/overlay datapath
  typedef struct packed {
    logic        latchStop;
    stopReason_t reason;
    logic        latchOvl;
  } ctrlStrobe_t;

endpackage

// File: rtl/insn_sched_dp.sv
module insn_sched_dp
  import insn_sched_pkg::*;
#(
  parameter int OVL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [OVL_W-1:0] ovlNum,
  output logic             ovlIsHalt,
  output logic [1:0]       stopReason,
  output logic [OVL_W-1:0] ovlOut
);

  localparam logic [OVL_W-1:0] HALT_OVL = {OVL_W{1'b1}};

  stopReason_t      reasonQ;
  logic [OVL_W-1:0] ovlQ;

  assign ovlIsHalt = (ovlNum == HALT_OVL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reasonQ <= R_INVALID;
      ovlQ    <= '0;
    end else begin
      if (strobe.latchStop) reasonQ <= strobe.reason;
      if (strobe.latchOvl)  ovlQ    <= ovlNum;
    end
  end

  assign stopReason = reasonQ;
  assign ovlOut     = ovlQ;

  // R10: the reported cause only moves when a new stop is latched
  p_reason_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchStop |=> $stable(stopReason));

  // R9: an overlay request to the reserved number reports halt
  p_halt_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchOvl && ovlIsHalt) |=> (stopReason == R_HALT && ovlOut == HALT_OVL));

endmodule

// File: rtl/insn_sched_ctrl.sv
module insn_sched_ctrl
  import insn_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runMode,
  input  logic        stepReq,
  input  logic        stopClr,
  input  logic        isPrefix,
  input  logic        isLdc,
  input  logic        writesPc,
  input  logic        isOvl,
  input  logic        invalid,
  input  logic        ovlIsHalt,
  output schedState_t state,
  output ctrlStrobe_t strobe,
  output logic        fetchStall,
  output logic        wbEn,
  output logic        pcIncEn
);

  schedState_t stateNext;
  logic        inExec;
  logic        dblPrefix;
  logic        stopNow;
  schedState_t afterDone;
  stopReason_t reasonNext;

  assign inExec    = (state == S_INST) || (state == S_PRFX);
  assign dblPrefix = (state == S_PRFX) && isPrefix;
  assign stopNow   = inExec && (invalid || dblPrefix || isOvl);
  assign afterDone = runMode ? S_INST : S_IDLE;

  always_comb begin
    if (invalid)        reasonNext = R_INVALID;
    else if (dblPrefix) reasonNext = R_DBLPFX;
    else if (ovlIsHalt) reasonNext = R_HALT;
    else                reasonNext = R_OVL;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (runMode || stepReq) stateNext = S_INST;
      S_INST, S_PRFX: begin
        if (stopNow)       stateNext = S_STOP;
        else if (isPrefix) stateNext = S_PRFX;
        else if (isLdc)    stateNext = S_LDC;
        else if (writesPc) stateNext = S_PCSTALL;
        else if (state == S_PRFX) stateNext = S_INST; // no idle exit after a prefix
        else               stateNext = afterDone;
      end
      S_LDC, S_PCSTALL: stateNext = afterDone;
      S_STOP: if (stopClr) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.latchStop = stopNow;
    strobe.reason    = reasonNext;
    strobe.latchOvl  = inExec && !invalid && !dblPrefix && isOvl;
  end

  assign pcIncEn    = inExec && !stopNow;
  assign wbEn       = inExec && !stopNow && !isPrefix;
  assign fetchStall = !pcIncEn;

  // R4: the constant-load stall lasts a single cycle
  p_ldc_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LDC) |=> (state == S_INST || state == S_IDLE));

  // R5: the PC-write stall lasts a single cycle
  p_pcstall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PCSTALL) |=> (state == S_INST || state == S_IDLE));

  // R3: a prefix never leads straight to idle
  p_prefix_no_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PRFX) |=> (state != S_IDLE));

  // R10: stop is left only through the clear
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP && !stopClr) |=> (state == S_STOP));

  // R11: no writeback or PC advance in a cycle that enters stop
  p_stop_no_wb_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inExec && (invalid || isOvl)) |-> (!wbEn && !pcIncEn && fetchStall));

  // R1: the state code stays within the defined set
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    state <= S_STOP);

endmodule

// File: rtl/insn_sched.sv
module insn_sched
  import insn_sched_pkg::*;
#(
  parameter int OVL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runMode,
  input  logic             stepReq,
  input  logic             stopClr,
  input  logic             isPrefix,
  input  logic             isLdc,
  input  logic             writesPc,
  input  logic             isOvl,
  input  logic             invalid,
  input  logic [OVL_W-1:0] ovlNum,
  output logic             fetchStall,
  output logic             wbEn,
  output logic             pcIncEn,
  output logic             stopped,
  output logic [1:0]       stopReason,
  output logic [OVL_W-1:0] ovlOut,
  output logic [2:0]       stateOut
);

  schedState_t state;
  ctrlStrobe_t strobe;
  logic        ovlIsHalt;

  insn_sched_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runMode   (runMode),
    .stepReq   (stepReq),
    .stopClr   (stopClr),
    .isPrefix  (isPrefix),
    .isLdc     (isLdc),
    .writesPc  (writesPc),
    .isOvl     (isOvl),
    .invalid   (invalid),
    .ovlIsHalt (ovlIsHalt),
    .state     (state),
    .strobe    (strobe),
    .fetchStall(fetchStall),
    .wbEn      (wbEn),
    .pcIncEn   (pcIncEn)
  );

  insn_sched_dp #(.OVL_W(OVL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ovlNum    (ovlNum),
    .ovlIsHalt (ovlIsHalt),
    .stopReason(stopReason),
    .ovlOut    (ovlOut)
  );

  assign stateOut = state;
  assign stopped  = (state == S_STOP);

endmodule

// File: tb/insn_sched_bench.sv
module insn_sched_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runMode = 0, stepReq = 0, stopClr = 0;
  logic       isPrefix = 0, isLdc = 0, writesPc = 0, isOvl = 0, invalid = 0;
  logic [7:0] ovlNum = 0;
  logic       fetchStall, wbEn, pcIncEn, stopped;
  logic [1:0] stopReason;
  logic [7:0] ovlOut;
  logic [2:0] stateOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int         ms = 0;
  logic [1:0] mReason = 0;
  logic [7:0] mOvl = 0;

  always #2 clk = ~clk;

  insn_sched u_insn_sched (
    .clk(clk), .rstN(rstN), .runMode(runMode), .stepReq(stepReq), .stopClr(stopClr),
    .isPrefix(isPrefix), .isLdc(isLdc), .writesPc(writesPc), .isOvl(isOvl),
    .invalid(invalid), .ovlNum(ovlNum), .fetchStall(fetchStall), .wbEn(wbEn),
    .pcIncEn(pcIncEn), .stopped(stopped), .stopReason(stopReason), .ovlOut(ovlOut),
    .stateOut(stateOut)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string pickTag(input int s, input bit r, input bit p, input bit l,
                                    input bit w, input bit o, input bit i, input logic [7:0] n);
    bit inExec = (s == 1 || s == 2);
    if (!inExec) return (s == 3) ? "R4" : (s == 4) ? "R5" : (s == 5) ? "R10" : "R2";
    if ((int'(p) + int'(l) + int'(w) + int'(o) + int'(i)) > 1) return "R11";
    if (i) return "R6";
    if (s == 2 && p) return "R7";
    if (o) return (n == 8'hFF) ? "R9" : "R8";
    if (p) return "R3";
    if (l) return "R4";
    if (w) return "R5";
    return r ? "R2" : ((s == 2) ? "R3" : "R2");
  endfunction

  function automatic int nextState(input int s, input bit r, input bit st, input bit c,
                                   input bit p, input bit l, input bit w, input bit o, input bit i);
    case (s)
      0: return (r || st) ? 1 : 0;
      1, 2: begin
        if (i || (s == 2 && p) || o) return 5;
        if (p) return 2;
        if (l) return 3;
        if (w) return 4;
        if (s == 2) return 1;
        return r ? 1 : 0;
      end
      3, 4: return r ? 1 : 0;
      default: return c ? 0 : 5;
    endcase
  endfunction

  task automatic doCycle(input bit r, input bit st, input bit c, input bit p, input bit l,
                         input bit w, input bit o, input bit i, input logic [7:0] n);
    string tag;
    bit inExec, stopNow;
    @(negedge clk);
    runMode = r; stepReq = st; stopClr = c; isPrefix = p; isLdc = l;
    writesPc = w; isOvl = o; invalid = i; ovlNum = n;
    #1;
    tag = pickTag(ms, r, p, l, w, o, i, n);
    inExec  = (ms == 1 || ms == 2);
    stopNow = inExec && (i || (ms == 2 && p) || o);
    chk(tag, "wbEn", int'(wbEn), int'(inExec && !stopNow && !p));
    chk(tag, "pcIncEn", int'(pcIncEn), int'(inExec && !stopNow));
    chk(tag, "fetchStall", int'(fetchStall), int'(!(inExec && !stopNow)));
    if (stopNow) begin
      if (i) mReason = 2'd0;
      else if (ms == 2 && p) mReason = 2'd1;
      else if (n == 8'hFF) mReason = 2'd3;
      else mReason = 2'd2;
    end
    if (inExec && !i && !(ms == 2 && p) && o) mOvl = n;
    ms = nextState(ms, r, st, c, p, l, w, o, i);
    @(posedge clk);
    #1;
    chk(tag, "stateOut", int'(stateOut), ms);
    chk(tag, "stopped", int'(stopped), int'(ms == 5));
    if (ms == 5) chk(tag, "stopReason", int'(stopReason), int'(mReason));
    chk(tag, "ovlOut", int'(ovlOut), int'(mOvl));
  endtask

  // shorthand: plain instruction
  task automatic plain(input bit r);
    doCycle(r, 0, 0, 0, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "stateOut", int'(stateOut), 0);
    chk("R1", "stopped", int'(stopped), 0);
    chk("R1", "fetchStall", int'(fetchStall), 1);
    chk("R1", "wbEn", int'(wbEn), 0);
    chk("R1", "pcIncEn", int'(pcIncEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "stateOut after release", int'(stateOut), 0);

    // R2 run, then R3 prefix followed by R4 constant load
    plain(1); plain(1);
    doCycle(1, 0, 0, 1, 0, 0, 0, 0, 8'h00);
    doCycle(1, 0, 0, 0, 1, 0, 0, 0, 8'h00);
    plain(1);
    // R5 PC write after prefix
    doCycle(1, 0, 0, 1, 0, 0, 0, 0, 8'h00);
    doCycle(1, 0, 0, 0, 0, 1, 0, 0, 8'h00);
    plain(1);
    // R3 prefix pending while runMode drops: must still execute
    doCycle(0, 0, 0, 1, 0, 0, 0, 0, 8'h00);
    plain(0); plain(0);
    // R2 step from idle
    doCycle(0, 1, 0, 0, 0, 0, 0, 0, 8'h00);
    plain(0);
    // R7 double prefix, R10 held with flags, then clear
    doCycle(1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    doCycle(1, 0, 0, 1, 0, 0, 0, 0, 8'h00);
    doCycle(1, 0, 0, 1, 1, 0, 0, 0, 8'h00);
    doCycle(1, 1, 0, 1, 1, 1, 1, 1, 8'h12);
    doCycle(1, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    // R8 overlay 254
    plain(1);
    doCycle(1, 0, 0, 0, 0, 0, 1, 0, 8'hFE);
    doCycle(1, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    // R9 halt
    plain(1);
    doCycle(1, 0, 0, 0, 0, 0, 1, 0, 8'hFF);
    doCycle(1, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    // R11 invalid with overlay, R6
    plain(1);
    doCycle(1, 0, 0, 0, 1, 0, 1, 1, 8'h33);
    doCycle(1, 0, 1, 0, 0, 0, 0, 0, 8'h00);
    // R6 invalid alone
    plain(1);
    doCycle(1, 0, 0, 0, 0, 0, 0, 1, 8'h00);
    doCycle(0, 0, 1, 0, 0, 0, 0, 0, 8'h00);

    // constrained random
    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      bit r  = ($urandom % 10) < 8;
      bit st = ($urandom % 10) == 0;
      bit c  = ($urandom % 10) < 3;
      bit p  = ($urandom % 100) < 15;
      bit l  = ($urandom % 100) < 15;
      bit w  = ($urandom % 100) < 10;
      bit o  = ($urandom % 100) < 4;
      bit i  = ($urandom % 100) < 3;
      logic [7:0] n = (($urandom % 10) < 3) ? 8'hFF : 8'($urandom);
      doCycle(r, st, c, p, l, w, o, i, n);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule